// File: doc/BRIEF.md
# I2C Event Flag and Status Unit

This unit sits between a byte-level I2C bus engine and a processor register port. The engine reports bus events as single-cycle pulses on a one-hot-per-event input vector. These events include start and repeated start sent, address byte sent, data byte sent, arbitration lost, own-address and general-call match, byte received, stop or repeated start seen while addressed, and bus error. On an event, the unit raises a sticky event flag and holds SCL low until software responds. It also records a status code describing the event.

Software reads a control word and a status word through a one-bit address and an 8-bit write port. The status word shows the event's code from the cycle after the flag rises. At all other times it shows a fixed "nothing to report" code. An interrupt request is formed from the flag, a local enable held in the control word, and a global enable input. A separate input pair models a power-down address wait that is cut short by another wake-up source. When that happens, the unit drops back to idle.

Top module: `i2c_evt_flag_unit`

## Requirements
- R1: After reset the flag is 0, the overrun bit is 0, SCL is released (`scl_hold_o`=0), the local enable is 0, and the status word (address 1) reads 8'hF8.
- R2: When the flag is clear, a pulse on any bit of `evt_i` sets the flag and asserts `scl_hold_o` from the next clock edge. `scl_hold_o` stays high for as long as the flag is set.
- R3: The status code for event bit k is (k+1)*8. The codes are: 0 start sent=08, 1 repeated start sent=10, 2 address sent=18, 3 data sent=20, 4 arbitration lost=28, 5 own address match=30, 6 general call match=38, 7 data received=40, 8 stop/repeated start received while addressed=48, 9 bus error=50. Bits [2:0] of every status value are 0.
- R4: The status word reads 8'hF8 in the first cycle after the flag rises. It shows the event code from the following cycle on, and reads 8'hF8 whenever the flag is clear.
- R5: When several event bits pulse in the same cycle, the lowest-numbered bit sets the status code.
- R6: Writing the control word (address 0) with bit 7=1 clears the flag and releases SCL after that edge. A write with bit 7=0 leaves the flag set. The control word layout is: bit 7 flag, bit 6 overrun, bit 0 local enable (read/write); the other bits read 0.
- R7: `irq_o` is high exactly when the flag, the local enable and `gie_i` are all 1.
- R8: An event pulse that arrives while the flag is set is ignored, and the status code is unchanged. Such a pulse sets the sticky overrun bit 6. Writing 1 to bit 6 of the control word clears overrun.
- R9: When `pd_wait_i` and `wake_i` are high in the same cycle, the flag and overrun bit are cleared and SCL is released. Any event in that cycle is discarded, and the status word reads 8'hF8 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Event pulses from the bus engine, one bit per event |
| gie_i | input | 1 | Global interrupt enable |
| pd_wait_i | input | 1 | Engine is waiting for an address match in power-down |
| wake_i | input | 1 | Another wake-up source fired |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| scl_hold_o | output | 1 | Drive SCL low while high |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker watches every cycle for the following properties:
- An accepted event raises the SCL hold on the next edge.
- The hold stays up until a clearing write or an abort.
- The status reads the idle code in the cycle the flag rises, and never in the cycles after while the flag is held.
- Late events set overrun.
- An abort releases SCL.
- The interrupt never fires without both the flag and the global enable.

Only the directed scenarios can show the exact code for each event, the priority among simultaneous pulses, and that a zero write leaves the flag alone. They also show that the overrun and abort paths leave the stored code as specified.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned EVT_N   = 10;
  localparam int unsigned DW      = 8;
  localparam logic [7:0]  NO_INFO = 8'hF8;

  function automatic logic [7:0] evt_code(input int unsigned k);
    return 8'((k + 1) * 8);
  endfunction
endpackage

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
  parameter int unsigned N  = 10,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/i2c_evt_core.sv
module i2c_evt_core
  import i2c_evt_pkg::*;
#(
  parameter int unsigned N = EVT_N,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [IW-1:0] hit_idx_i,
  input  logic          abort_i,
  input  logic          clr_flag_i,
  input  logic          clr_ovr_i,
  input  logic          ie_we_i,
  input  logic          ie_d_i,
  output logic          flag_o,
  output logic          ovr_o,
  output logic          ie_o,
  output logic [7:0]    stat_o
);
  logic       flag_q, ovr_q, ie_q;
  logic [7:0] code_q, stat_q;
  logic [7:0] code_tab [N];

  for (genvar k = 0; k < N; k++) begin : g_code
    assign code_tab[k] = evt_code(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
      code_q <= NO_INFO;
      stat_q <= NO_INFO;
    end else begin
      if (ie_we_i) ie_q <= ie_d_i;
      if (abort_i) begin
        flag_q <= 1'b0;
        ovr_q  <= 1'b0;
        stat_q <= NO_INFO;
      end else begin
        if (hit_i && !flag_q) begin
          flag_q <= 1'b1;
          code_q <= code_tab[hit_idx_i];
        end else if (clr_flag_i) begin
          flag_q <= 1'b0;
        end
        if (hit_i && flag_q)  ovr_q <= 1'b1;
        else if (clr_ovr_i)   ovr_q <= 1'b0;
        // status trails the flag by one cycle
        stat_q <= flag_q ? code_q : NO_INFO;
      end
    end
  end

  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;
  assign ie_o   = ie_q;
  assign stat_o = flag_q ? stat_q : NO_INFO;
endmodule

// File: rtl/i2c_evt_regif.sv
module i2c_evt_regif (
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  input  logic       flag_i,
  input  logic       ovr_i,
  input  logic       ie_i,
  input  logic [7:0] stat_i,
  output logic       clr_flag_o,
  output logic       clr_ovr_o,
  output logic       ie_we_o,
  output logic       ie_d_o,
  output logic [7:0] rdata_o
);
  logic ctrl_we;
  assign ctrl_we    = wr_en_i && !addr_i;
  assign clr_flag_o = ctrl_we && wdata_i[7];
  assign clr_ovr_o  = ctrl_we && wdata_i[6];
  assign ie_we_o    = ctrl_we;
  assign ie_d_o     = wdata_i[0];
  assign rdata_o    = addr_i ? stat_i : {flag_i, ovr_i, 5'b0, ie_i};
endmodule

// File: rtl/i2c_evt_flag_unit.sv
module i2c_evt_flag_unit
  import i2c_evt_pkg::*;
#(
  parameter int unsigned NUM_EVT = EVT_N,
  localparam int unsigned IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               gie_i,
  input  logic               pd_wait_i,
  input  logic               wake_i,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               scl_hold_o,
  output logic               irq_o
);
  logic          hit, abort, flag, ovr, ie;
  logic          clr_flag, clr_ovr, ie_we, ie_d;
  logic [IW-1:0] hit_idx;
  logic [7:0]    stat_view;

  assign abort = pd_wait_i && wake_i;

  i2c_evt_prio #(.N(NUM_EVT)) u_prio (
    .req_i(evt_i), .valid_o(hit), .idx_o(hit_idx)
  );

  i2c_evt_core #(.N(NUM_EVT)) u_core (
    .clk_i, .rst_ni,
    .hit_i(hit), .hit_idx_i(hit_idx), .abort_i(abort),
    .clr_flag_i(clr_flag), .clr_ovr_i(clr_ovr),
    .ie_we_i(ie_we), .ie_d_i(ie_d),
    .flag_o(flag), .ovr_o(ovr), .ie_o(ie), .stat_o(stat_view)
  );

  i2c_evt_regif u_regif (
    .wr_en_i, .addr_i, .wdata_i,
    .flag_i(flag), .ovr_i(ovr), .ie_i(ie), .stat_i(stat_view),
    .clr_flag_o(clr_flag), .clr_ovr_o(clr_ovr),
    .ie_we_o(ie_we), .ie_d_o(ie_d), .rdata_o
  );

  assign scl_hold_o = flag;
  assign irq_o      = flag && ie && gie_i;
endmodule

// File: rtl/i2c_evt_flag_chk.sv
module i2c_evt_flag_chk #(
  parameter int unsigned NUM_EVT = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               gie_i,
  input logic               pd_wait_i,
  input logic               wake_i,
  input logic               wr_en_i,
  input logic               addr_i,
  input logic [7:0]         wdata_i,
  input logic               scl_hold_o,
  input logic               irq_o,
  input logic [7:0]         stat_view,
  input logic               ovr
);
  logic abrt, clr_wr;
  assign abrt   = pd_wait_i && wake_i;
  assign clr_wr = wr_en_i && !addr_i && wdata_i[7];

  // R2
  evt_sets_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i && !scl_hold_o && !abrt) |=> scl_hold_o);
  // R2
  hold_persists_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !clr_wr && !abrt) |=> scl_hold_o);
  // R4
  stat_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> stat_view == 8'hF8);
  // R4
  stat_loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && $past(scl_hold_o)) |-> stat_view != 8'hF8);
  // R3
  stat_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_view[2:0] == 3'b000);
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (scl_hold_o && gie_i));
  // R8
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && |evt_i && !abrt) |=> ovr);
  // R9
  abort_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abrt |=> (!scl_hold_o && !ovr));
endmodule

bind i2c_evt_flag_unit i2c_evt_flag_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .gie_i(gie_i),
  .pd_wait_i(pd_wait_i), .wake_i(wake_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .scl_hold_o(scl_hold_o),
  .irq_o(irq_o), .stat_view(stat_view), .ovr(ovr)
);

// File: tb/sim_i2c_evt_flag_unit.sv
`timescale 1ns/1ps
module sim_i2c_evt_flag_unit;
  localparam int N = 10;
  logic clk_i = 0, rst_ni = 0;
  logic [N-1:0] evt_i = '0;
  logic gie_i = 0, pd_wait_i = 0, wake_i = 0, wr_en_i = 0, addr_i = 0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic scl_hold_o, irq_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  i2c_evt_flag_unit u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic wr_ctrl(logic [7:0] d);
    @(negedge clk_i); addr_i = 0; wdata_i = d; wr_en_i = 1;
    @(posedge clk_i); @(negedge clk_i); wr_en_i = 0; wdata_i = '0;
  endtask

  // pulse events; return at negedge after the accepting edge
  task automatic pulse(logic [N-1:0] e);
    @(negedge clk_i); evt_i = e;
    @(posedge clk_i); @(negedge clk_i); evt_i = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b1, d); chk("R1 status", d, 8'hF8);
    rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 scl", {7'b0, scl_hold_o}, 8'h00);
  endtask

  task automatic t_each_event;
    logic [7:0] d;
    for (int k = 0; k < N; k++) begin
      pulse(N'(1) << k);
      chk("R2 hold", {7'b0, scl_hold_o}, 8'h01);
      rd(1'b1, d); chk("R4 lag", d, 8'hF8);
      @(negedge clk_i);
      rd(1'b1, d); chk("R3 code", d, 8'((k + 1) * 8));
      @(negedge clk_i);
      chk("R2 held", {7'b0, scl_hold_o}, 8'h01);
      wr_ctrl(8'h80);
      chk("R6 release", {7'b0, scl_hold_o}, 8'h00);
      rd(1'b1, d); chk("R4 clear", d, 8'hF8);
    end
  endtask

  task automatic t_prio;
    logic [7:0] d;
    pulse(10'b10_0101_0000);
    @(negedge clk_i);
    rd(1'b1, d); chk("R5 prio", d, 8'h28);
    wr_ctrl(8'h80);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    pulse(10'b00_0000_0010);
    wr_ctrl(8'h7E);
    chk("R6 zero write", {7'b0, scl_hold_o}, 8'h01);
    rd(1'b0, d); chk("R6 ctrl", d, 8'h80);
    wr_ctrl(8'h80);
    rd(1'b0, d); chk("R6 cleared", d, 8'h00);
  endtask

  task automatic t_irq;
    wr_ctrl(8'h01);
    gie_i = 1; #1;
    chk("R7 no flag", {7'b0, irq_o}, 8'h00);
    pulse(10'b00_1000_0000);
    chk("R7 all set", {7'b0, irq_o}, 8'h01);
    gie_i = 0; #1;
    chk("R7 gie off", {7'b0, irq_o}, 8'h00);
    gie_i = 1;
    wr_ctrl(8'h80); // also clears local enable
    pulse(10'b00_1000_0000);
    chk("R7 ie off", {7'b0, irq_o}, 8'h00);
    wr_ctrl(8'h80);
    gie_i = 0;
  endtask

  task automatic t_overrun;
    logic [7:0] d;
    pulse(10'b00_0010_0000);
    @(negedge clk_i);
    pulse(10'b10_0000_0000);
    @(negedge clk_i);
    rd(1'b1, d); chk("R8 code kept", d, 8'h30);
    rd(1'b0, d); chk("R8 ovr set", d, 8'hC0);
    wr_ctrl(8'h40);
    rd(1'b0, d); chk("R8 ovr clr", d, 8'h80);
    wr_ctrl(8'h80);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    pulse(10'b00_0000_0100);
    pulse(10'b00_0000_0001);
    @(negedge clk_i); pd_wait_i = 1; wake_i = 1; evt_i = 10'b1;
    @(posedge clk_i); @(negedge clk_i);
    pd_wait_i = 0; wake_i = 0; evt_i = '0;
    chk("R9 scl", {7'b0, scl_hold_o}, 8'h00);
    rd(1'b0, d); chk("R9 ctrl", d, 8'h00);
    rd(1'b1, d); chk("R9 status", d, 8'hF8);
    pd_wait_i = 1;
    pulse(10'b00_0000_0001);
    pd_wait_i = 0;
    chk("R9 wait alone", {7'b0, scl_hold_o}, 8'h01);
    wr_ctrl(8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_each_event();
    t_prio();
    t_w1c();
    t_irq();
    t_overrun();
    t_abort();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule